// File: doc/BRIEF.md
# Timer-Synchronized Chip-Enable Reset Controller

This block turns a rising chip-enable level into a program restart, but only at a moment chosen by a free-running interval timer. A prescaler divides the instruction-cycle clock (225 kHz, one instruction every 4.44 µs) into a periodic one-cycle tick. Four tick periods can be selected: 1 ms, 5 ms, 100 ms and 250 ms. Each tick sets a carry flag. The program polls this flag with a read strobe. Each read returns the flag's value and clears the flag.

A rising edge on the chip-enable input arms a pending restart. The restart is issued at the next tick, not at the edge itself. The restart is a single-cycle active-high pulse that sends execution back to address 0000H. The same pulse clears the prescaler so the timer restarts from zero. If a flag read lands in the same cycle as that tick, the read wins and the restart moves to the next tick. A program whose polling lines up with every tick therefore never gets restarted. If chip-enable falls before a qualifying tick, the pending restart is dropped.

The controller is a three-state machine:
- `ST_IDLE` (nothing pending) moves to `ST_ARMED` on a chip-enable rise.
- `ST_ARMED` goes back to `ST_IDLE` when chip-enable is low.
- `ST_ARMED` stays in `ST_ARMED` when the tick collides with a read (defer).
- `ST_ARMED` moves to `ST_FIRE` on a tick with no read.
- `ST_FIRE` drives the restart pulse and always returns to `ST_IDLE`.

Top module: `tsync_ce_reset`

## Requirements
- R1: While `rst_n` is low, `ce_rst`, `carry_flag` and `tick` are all 0.
- R2: `per_sel` picks the tick period in cycles: 00 gives DIV0 (225), 01 gives DIV1 (1125), 10 gives DIV2 (22500) and 11 gives DIV3 (56250). `tick` is high for exactly one cycle per period.
- R3: A 0-to-1 change on `ce_in` produces no restart in the cycle of the edge. The restart comes in the cycle after the first following tick during which `flag_rd` is low and `ce_in` is high.
- R4: A tick that coincides with `flag_rd` high issues no restart. The pending restart carries over to the next tick.
- R5: If every tick after the edge coincides with a flag read, `ce_rst` stays 0 for as long as this continues.
- R6: If `ce_in` goes low while a restart is pending, the restart is cancelled, and later ticks issue none.
- R7: One chip-enable rise yields at most one restart. Further ticks while `ce_in` stays high issue none.
- R8: `ce_rst` is high for exactly one cycle.
- R9: The restart clears the prescaler, so the next tick arrives exactly the selected period of cycles after the `ce_rst` cycle.
- R10: A tick sets `carry_flag` to 1 for the next cycle. A read returns the current `carry_flag` and clears it for the next cycle, unless a tick falls in that same cycle, in which case the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_in | input | 1 | Chip-enable level, synchronous to `clk` |
| per_sel | input | 2 | Tick period select (see R2) |
| flag_rd | input | 1 | Strobe: an instruction reads the carry flag this cycle |
| carry_flag | output | 1 | Current carry flag, the value a read returns |
| tick | output | 1 | One-cycle timer carry set pulse |
| ce_rst | output | 1 | One-cycle restart pulse (program counter to 0000H) |

## Verification
Some properties are checked on every cycle by assertions:
- the restart pulse is one cycle wide and always follows a read-free tick taken with chip-enable high;
- a low chip-enable blocks the next cycle's restart;
- the flag sets, clears and holds as described in R10;
- the prescaler is zeroed after a restart and stays inside its bound.

Other behaviour needs a sequence of events, so only the directed scenarios can show it:
- the exact tick period for each select value;
- the deferral from one tick to the next;
- unbounded starvation under aligned polling;
- that one edge restarts at most once.

// File: rtl/ce_rst_pkg.sv
package ce_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } cer_state_e;

    typedef enum logic [1:0] {
        PER_1MS   = 2'b00,
        PER_5MS   = 2'b01,
        PER_100MS = 2'b10,
        PER_250MS = 2'b11
    } per_sel_e;

    localparam int unsigned NUM_PERIODS = 4;

endpackage

// File: rtl/cer_prescaler.sv
module cer_prescaler
    import ce_rst_pkg::*;
#(
    parameter int unsigned DIV0 = 225,
    parameter int unsigned DIV1 = 1125,
    parameter int unsigned DIV2 = 22500,
    parameter int unsigned DIV3 = 56250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       clr,
    output logic       tick
);
    localparam int unsigned DMAX_01 = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int unsigned DMAX_23 = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int unsigned DMAX    = (DMAX_01 > DMAX_23) ? DMAX_01 : DMAX_23;
    localparam int          CW      = $clog2(DMAX + 1);

    function automatic int unsigned div_of(input int idx);
        case (idx)
            0:       return DIV0;
            1:       return DIV1;
            2:       return DIV2;
            default: return DIV3;
        endcase
    endfunction

    // terminal-count table, one entry per selectable period
    logic [CW-1:0] term_tab [NUM_PERIODS];
    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_term
        assign term_tab[g] = CW'(div_of(g) - 1);
    end

    logic [CW-1:0] term;
    logic [CW-1:0] cnt;

    always_comb begin
        unique case (per_sel_e'(sel))
            PER_1MS:   term = term_tab[0];
            PER_5MS:   term = term_tab[1];
            PER_100MS: term = term_tab[2];
            PER_250MS: term = term_tab[3];
            default:   term = term_tab[0];
        endcase
    end

    // wraps at or past the terminal count so a shorter select never overruns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt >= term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = rst_n && (cnt >= term);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(DMAX));

    p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/cer_carry_flag.sv
module cer_carry_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rd,
    output logic flag
);
    // a set pulse outranks a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tick) begin
            flag <= 1'b1;
        end else if (rd) begin
            flag <= 1'b0;
        end
    end

    p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag);

    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !tick) |=> !flag);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !tick) |=> $stable(flag));

endmodule

// File: rtl/cer_arm_fsm.sv
module cer_arm_fsm
    import ce_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in,
    input  logic tick,
    input  logic rd,
    output logic ce_rst
);
    cer_state_e state;
    cer_state_e state_nx;
    logic       ce_q;
    logic       ce_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q <= 1'b0;
        end else begin
            ce_q <= ce_in;
        end
    end

    assign ce_rise = ce_in && !ce_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ce_rise) begin
                    state_nx = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!ce_in) begin
                    state_nx = ST_IDLE;      // cancel
                end else if (tick && !rd) begin
                    state_nx = ST_FIRE;      // take the restart
                end
                // tick with a read: stay armed (defer)
            end
            ST_FIRE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs
    always_comb begin
        ce_rst = (state == ST_FIRE);
    end

    p_fire_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rst |-> $past(tick && !rd && ce_in));

    p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd) |=> !ce_rst);

    p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_in |=> !ce_rst);

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rst |=> !ce_rst);

endmodule

// File: rtl/tsync_ce_reset.sv
module tsync_ce_reset
    import ce_rst_pkg::*;
#(
    parameter int unsigned DIV0 = 225,
    parameter int unsigned DIV1 = 1125,
    parameter int unsigned DIV2 = 22500,
    parameter int unsigned DIV3 = 56250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_in,
    input  logic [1:0] per_sel,
    input  logic       flag_rd,
    output logic       carry_flag,
    output logic       tick,
    output logic       ce_rst
);
    logic tick_w;
    logic rst_w;

    cer_prescaler #(
        .DIV0(DIV0),
        .DIV1(DIV1),
        .DIV2(DIV2),
        .DIV3(DIV3)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (per_sel),
        .clr  (rst_w),
        .tick (tick_w)
    );

    cer_carry_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w),
        .rd   (flag_rd),
        .flag (carry_flag)
    );

    cer_arm_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_in (ce_in),
        .tick  (tick_w),
        .rd    (flag_rd),
        .ce_rst(rst_w)
    );

    assign tick   = tick_w;
    assign ce_rst = rst_w;

    p_no_tick_with_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rst |-> !tick);

endmodule

// File: tb/tsync_ce_reset_tb.sv
module tsync_ce_reset_tb;
    localparam int CLK_P = 10;
    localparam int D0 = 6;
    localparam int D1 = 9;
    localparam int D2 = 13;
    localparam int D3 = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_in = 1'b0;
    logic [1:0] per_sel = 2'b00;
    logic       flag_rd = 1'b0;
    logic       carry_flag;
    logic       tick;
    logic       ce_rst;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    tsync_ce_reset #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .per_sel(per_sel),
        .flag_rd(flag_rd), .carry_flag(carry_flag), .tick(tick), .ce_rst(ce_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_tick();
        while (!tick) step();
    endtask

    task automatic idle_ce(input int n);
        ce_in = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 ce_rst in reset", ce_rst, 0);
        chk("R1 carry_flag in reset", carry_flag, 0);
        chk("R1 tick in reset", tick, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_period(input logic [1:0] sel, input int len);
        int n;
        per_sel = sel;
        wait_tick(); step(); wait_tick(); step();
        chk("R2 tick one cycle wide", tick, 0);
        n = 1;
        while (!tick) begin step(); n++; end
        chk($sformatf("R2 period sel=%0d", sel), n, len);
    endtask

    task automatic t_fire();
        int n;
        per_sel = 2'b00;
        idle_ce(3);
        wait_tick(); step();
        ce_in = 1'b1;
        chk("R3 no restart on CE edge", ce_rst, 0);
        while (!tick) begin
            step();
            if (!tick) chk("R3 no restart before tick", ce_rst, 0);
        end
        chk("R3 no restart in tick cycle", ce_rst, 0);
        step();
        chk("R3 restart after tick", ce_rst, 1);
        n = 0;
        step(); n++;
        chk("R8 restart one cycle", ce_rst, 0);
        while (!tick) begin step(); n++; end
        chk("R9 prescaler cleared by restart", n, D0);
        step();
        chk("R7 no second restart", ce_rst, 0);
        wait_tick(); step();
        chk("R7 no restart while CE held", ce_rst, 0);
        ce_in = 1'b0;
    endtask

    task automatic t_defer();
        idle_ce(3);
        wait_tick(); step();
        ce_in = 1'b1;
        step();
        wait_tick();
        flag_rd = 1'b1;
        step();
        flag_rd = 1'b0;
        chk("R4 colliding read blocks restart", ce_rst, 0);
        wait_tick(); step();
        chk("R4 restart at following tick", ce_rst, 1);
        ce_in = 1'b0;
    endtask

    task automatic t_starve();
        idle_ce(3);
        wait_tick(); step();
        ce_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wait_tick();
            flag_rd = 1'b1;
            step();
            flag_rd = 1'b0;
            chk($sformatf("R5 starved tick %0d", k), ce_rst, 0);
        end
        ce_in = 1'b0;
        step();
    endtask

    task automatic t_cancel();
        idle_ce(3);
        wait_tick(); step();
        ce_in = 1'b1;
        step(); step();
        ce_in = 1'b0;
        wait_tick(); step();
        chk("R6 cancelled at first tick", ce_rst, 0);
        wait_tick(); step();
        chk("R6 cancelled at second tick", ce_rst, 0);
    endtask

    task automatic t_flag();
        idle_ce(2);
        wait_tick(); step();
        chk("R10 tick sets flag", carry_flag, 1);
        flag_rd = 1'b1;
        chk("R10 read returns 1", carry_flag, 1);
        step();
        flag_rd = 1'b0;
        chk("R10 read clears flag", carry_flag, 0);
        wait_tick();
        flag_rd = 1'b1;
        chk("R10 read before set returns 0", carry_flag, 0);
        step();
        flag_rd = 1'b0;
        chk("R10 tick wins over clearing read", carry_flag, 1);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog R2 act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_period(2'b00, D0);
        t_period(2'b01, D1);
        t_period(2'b10, D2);
        t_period(2'b11, D3);
        per_sel = 2'b00;
        t_fire();
        t_defer();
        t_starve();
        t_cancel();
        t_flag();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule